// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel NOR flash. A client hands it one request: an opcode (word program, sector erase, block erase or chip erase), a target word address and, for a program, a data word. The block sends the unlock-and-command write sequence that the flash expects. It then reads status at the target address until the toggle bit stops changing, and finishes with a one-cycle done pulse plus an error flag.

A status word sampled at the moment the flash finishes can look settled while the part is still busy, or look busy once it has finished. For this reason the poller does not accept a single matching pair of reads. It needs two more valid reads after the first match. For a program, it also waits a fixed settling interval and then reads the whole word back once to compare it with the data written. A per-operation cycle budget ends a poll whose toggle bit never settles and reports an error.

The bus side is a plain synchronous master. The write or read strobe stays up, with address and data held, until the slave returns a one-cycle acknowledge. Read data is taken in the acknowledge cycle.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A request is taken only in a cycle where `busy_o` is low and `req_valid_i` is high. `busy_o` goes high in the next cycle and stays high through the done cycle. A request raised while busy has no effect on the bus.
- R2: A program sends exactly four writes, as (address, data) pairs in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), (target address, data word).
- R3: Every erase sends exactly six writes: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), then a last write chosen by opcode. Sector erase (opcode 1) writes 0x50 to the target address. Block erase (opcode 2) writes 0x30 to the target address. Chip erase (opcode 3) writes 0x10 to 0x555. Program is opcode 0.
- R4: A strobe and its address and data stay stable until `bus_ack_i`. Write and read strobes are never high together.
- R5: No status read is issued before the final command write is acknowledged. Every read goes to the target address.
- R6: A read whose bit 6 matches bit 6 of the previous status read is valid. The first valid read is a candidate. Completion needs two more valid reads in a row after it. Any invalid read restarts the search. Done is never reported while the flash is still toggling.
- R7: For a program, a read whose bit 7 equals bit 7 of the written data also counts as valid.
- R8: After a program settles, the block waits `SETTLE_CYC` cycles with no access. It then makes one verify read. Any difference from the written word sets the error flag.
- R9: If status has not settled when a read is acknowledged after `PROG_TMO_CYC` (program) or `ERASE_TMO_CYC` (erase) polling cycles, the block finishes with the error flag set.
- R10: `done_o` is a one-cycle pulse. `err_o` is high only with `done_o`. The block is idle in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr_i | input | ADDR_W | Target word address |
| req_data_i | input | DATA_W | Data word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or verify mismatch, valid with done |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data, taken with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |

## Verification
The hardest case to reach is a busy flash that returns one repeated toggle value in the middle of an operation. That forms a false candidate, and the next read has to cancel it. A status sequence that ends just as the part finishes is similarly hard to produce on demand. The bench flash model counts status reads against a chosen busy length. On request it suppresses one toggle at a chosen read, and it randomises acknowledge latency so that the candidate lands at different read positions. It then checks that done never arrives while the model is still busy and that the number of settled reads lies in the range the confirmation rule allows.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_SETTLE,
    ST_VERIFY,
    ST_DONE
  } ctrl_st_e;

  localparam int unsigned PROG_WRITES  = 4;
  localparam int unsigned ERASE_WRITES = 6;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  flash_op_e           op_i,
  input  logic [2:0]          step_i,
  input  logic [ADDR_W-1:0]   tgt_addr_i,
  input  logic [DATA_W-1:0]   tgt_data_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                last_o
);
  localparam logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'(12'h2AA);

  logic [7:0] code;

  always_comb begin
    addr_o = UNLOCK_A;
    code   = 8'h00;
    data_o = '0;
    last_o = 1'b0;
    if (op_i == OP_PROG) begin
      unique case (step_i)
        3'd0: begin addr_o = UNLOCK_A; code = 8'hAA; end
        3'd1: begin addr_o = UNLOCK_B; code = 8'h55; end
        3'd2: begin addr_o = UNLOCK_A; code = 8'hA0; end
        default: begin addr_o = tgt_addr_i; last_o = 1'b1; end
      endcase
      data_o = last_o ? tgt_data_i : DATA_W'(code);
    end else begin
      unique case (step_i)
        3'd0, 3'd3: begin addr_o = UNLOCK_A; code = 8'hAA; end
        3'd1, 3'd4: begin addr_o = UNLOCK_B; code = 8'h55; end
        3'd2:       begin addr_o = UNLOCK_A; code = 8'h80; end
        default: begin
          last_o = 1'b1;
          unique case (op_i)
            OP_SECT: begin addr_o = tgt_addr_i; code = 8'h50; end
            OP_BLK:  begin addr_o = tgt_addr_i; code = 8'h30; end
            default: begin addr_o = UNLOCK_A;   code = 8'h10; end
          endcase
        end
      endcase
      data_o = DATA_W'(code);
    end
  end
endmodule

// File: rtl/flash_toggle_judge.sv
module flash_toggle_judge #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TOG_BIT     = 6,
  parameter int unsigned POLL_BIT    = 7,
  parameter int unsigned EXTRA_READS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              prog_i,
  input  logic              exp_poll_i,
  output logic              settled_o
);
  localparam int unsigned CW = $clog2(EXTRA_READS + 2);
  localparam logic [CW-1:0] RUN_MAX = CW'(EXTRA_READS);

  logic          have_q, prev_q;
  logic [CW-1:0] run_q;
  logic          valid;

  // valid: toggle bit held, or (program) polled bit already shows true data
  assign valid = have_q &&
                 ((rdata_i[TOG_BIT] == prev_q) ||
                  (prog_i && (rdata_i[POLL_BIT] == exp_poll_i)));
  assign settled_o = sample_i && valid && (run_q == RUN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      run_q  <= '0;
    end else if (sample_i) begin
      have_q <= 1'b1;
      prev_q <= rdata_i[TOG_BIT];
      if (!valid)                run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/flash_countdown.sv
module flash_countdown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned PROG_TMO_CYC  = 2000,
  parameter int unsigned ERASE_TMO_CYC = 8000000,
  parameter int unsigned SETTLE_CYC    = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i
);
  localparam int unsigned TMO_MAX = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int unsigned TMO_W   = $clog2(TMO_MAX + 1);
  localparam int unsigned SET_W   = $clog2(SETTLE_CYC + 1);

  ctrl_st_e          st_q;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        step_q;
  logic              err_q;

  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;
  logic              seq_last;
  logic              is_prog;
  logic              cmd_end, poll_ack, settled, tmo_zero, settle_zero, settle_load;

  assign is_prog     = (op_q == OP_PROG);
  assign cmd_end     = (st_q == ST_CMD) && bus_ack_i && seq_last;
  assign poll_ack    = (st_q == ST_POLL) && bus_ack_i;
  assign settle_load = poll_ack && settled && is_prog;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .op_i       (op_q),
    .step_i     (step_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .addr_o     (seq_addr),
    .data_o     (seq_data),
    .last_o     (seq_last)
  );

  flash_toggle_judge #(.DATA_W(DATA_W)) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (cmd_end),
    .sample_i   (poll_ack),
    .rdata_i    (bus_rdata_i),
    .prog_i     (is_prog),
    .exp_poll_i (data_q[7]),
    .settled_o  (settled)
  );

  flash_countdown #(.CNT_W(TMO_W)) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cmd_end),
    .load_val_i (is_prog ? TMO_W'(PROG_TMO_CYC - 1) : TMO_W'(ERASE_TMO_CYC - 1)),
    .en_i       (st_q == ST_POLL),
    .zero_o     (tmo_zero)
  );

  flash_countdown #(.CNT_W(SET_W)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (settle_load),
    .load_val_i (SET_W'(SETTLE_CYC - 1)),
    .en_i       (st_q == ST_SETTLE),
    .zero_o     (settle_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      step_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          op_q   <= flash_op_e'(req_op_i);
          addr_q <= req_addr_i;
          data_q <= req_data_i;
          step_q <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_CMD;
        end
        ST_CMD: if (bus_ack_i) begin
          if (seq_last) st_q <= ST_POLL;
          else          step_q <= step_q + 1'b1;
        end
        ST_POLL: if (bus_ack_i) begin
          if (settled) st_q <= is_prog ? ST_SETTLE : ST_DONE;
          else if (tmo_zero) begin
            err_q <= 1'b1;
            st_q  <= ST_DONE;
          end
        end
        ST_SETTLE: if (settle_zero) st_q <= ST_VERIFY;
        ST_VERIFY: if (bus_ack_i) begin
          err_q <= (bus_rdata_i != data_q);
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign err_o       = done_o && err_q;
  assign bus_wr_o    = (st_q == ST_CMD);
  assign bus_rd_o    = (st_q == ST_POLL) || (st_q == ST_VERIFY);
  assign bus_addr_o  = (st_q == ST_CMD) ? seq_addr : addr_q;
  assign bus_wdata_o = (st_q == ST_CMD) ? seq_data : '0;
endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_wr_o,
  input logic              bus_rd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_wr_o && !bus_rd_o));
  assert_one_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));
  assert_wr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && !bus_ack_i) |=> (bus_wr_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  assert_rd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_ack_i) |=> (bus_rd_o && $stable(bus_addr_o)));
  assert_done_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  assert_err_with_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rd_o    (bus_rd_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int PTMO = 300;
  localparam int ETMO = 600;
  localparam int SETL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, done, err, wr, rd;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bwdata;
  logic [DW-1:0] brdata = '0;
  logic back = 1'b0;

  always #2.5 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_TMO_CYC(PTMO),
                    .ERASE_TMO_CYC(ETMO), .SETTLE_CYC(SETL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .busy_o(busy), .done_o(done),
    .err_o(err), .bus_wr_o(wr), .bus_rd_o(rd), .bus_addr_o(baddr),
    .bus_wdata_o(bwdata), .bus_rdata_i(brdata), .bus_ack_i(back));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(int op, int i, logic [AW-1:0] a);
    if (op == 0) return (i == 3) ? a : ((i == 1) ? AW'(12'h2AA) : AW'(12'h555));
    if (i == 1 || i == 4) return AW'(12'h2AA);
    if (i == 5) return (op == 3) ? AW'(12'h555) : a;
    return AW'(12'h555);
  endfunction

  function automatic logic [DW-1:0] exp_data(int op, int i, logic [DW-1:0] d);
    if (op == 0) begin
      case (i) 0: return 16'hAA; 1: return 16'h55; 2: return 16'hA0; default: return d; endcase
    end
    case (i)
      0, 3: return 16'hAA;
      1, 4: return 16'h55;
      2: return 16'h80;
      default: return (op == 1) ? 16'h50 : ((op == 2) ? 16'h30 : 16'h10);
    endcase
  endfunction

  // flash model state
  int cur_op; logic [AW-1:0] cur_addr; logic [DW-1:0] cur_data, cur_mask;
  int nwr, nrd, busy_left, busy_idx, glitch, n_final, lat, low_run, cur_gap, last_gap, last_wr_cyc;
  bit tog, rd_prev;

  function automatic int wr_total(int op); return (op == 0) ? 4 : 6; endfunction

  always @(negedge clk) begin
    if (!rd) low_run++;
    if (rd && !rd_prev) cur_gap = low_run;
    if (rd) low_run = 0;
    rd_prev = rd;
    if (back) back = 1'b0;
    else if (wr || rd) begin
      if (lat > 0) lat--;
      else begin
        back = 1'b1;
        lat = $urandom_range(0, 2);
        if (wr) begin
          chk(nwr < wr_total(cur_op), (cur_op == 0) ? "R2 write count" : "R3 write count", nwr, wr_total(cur_op));
          chk(baddr == exp_addr(cur_op, nwr, cur_addr), (cur_op == 0) ? "R2 addr" : "R3 addr",
              baddr, exp_addr(cur_op, nwr, cur_addr));
          chk(bwdata == exp_data(cur_op, nwr, cur_data), (cur_op == 0) ? "R2 data" : "R3 data",
              bwdata, exp_data(cur_op, nwr, cur_data));
          nwr++;
          if (nwr == wr_total(cur_op)) last_wr_cyc = cyc;
        end else begin
          nrd++;
          if (nwr != wr_total(cur_op)) chk(0, "R5 read before final write", nwr, wr_total(cur_op));
          if (baddr != cur_addr) chk(0, "R5 read address", baddr, cur_addr);
          last_gap = cur_gap;
          if (busy_left > 0) begin
            busy_idx++;
            if (busy_idx > 1 && busy_idx != glitch) tog = ~tog;
            brdata = DW'($urandom);
            brdata[6] = tog;
            brdata[7] = (cur_op == 0) ? ~cur_data[7] : 1'b0;
            busy_left--;
          end else begin
            n_final++;
            brdata = (cur_op == 0) ? (cur_data ^ cur_mask) : '1;
          end
        end
      end
    end
  end

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int b, input int g, input logic [DW-1:0] mask, input bit poke);
    bit exp_err, tmo;
    int wait_c;
    tmo = (b > 50000);
    exp_err = tmo || (op == 0 && mask != 0);
    cur_op = op; cur_addr = a; cur_data = d; cur_mask = mask;
    nwr = 0; nrd = 0; busy_left = b; busy_idx = 0; glitch = g; n_final = 0;
    tog = $urandom_range(0, 1);
    @(negedge clk);
    chk(!busy, "R1 idle before request", busy, 0);
    req_valid = 1'b1; req_op = op[1:0]; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R1 busy after accept", busy, 1);
    wait_c = 0;
    while (!done && wait_c < 20000) begin
      @(negedge clk);
      wait_c++;
      if (poke && wait_c == 8) begin
        req_valid = 1'b1; req_op = 2'd3; req_addr = ~a; req_data = ~d;
      end
      if (poke && wait_c == 10) req_valid = 1'b0;
      if (!done) chk(busy, "R1 busy held", busy, 1);
    end
    chk(done, "R10 done seen", done, 1);
    chk(err == exp_err, tmo ? "R9 error flag" : ((op == 0) ? "R8 error flag" : "R6 error flag"), err, exp_err);
    chk(nwr == wr_total(op), (op == 0) ? "R2 total writes" : "R3 total writes", nwr, wr_total(op));
    if (tmo) begin
      chk((cyc - last_wr_cyc) >= ((op == 0) ? PTMO : ETMO), "R9 timeout too early",
          cyc - last_wr_cyc, (op == 0) ? PTMO : ETMO);
      chk((cyc - last_wr_cyc) <= ((op == 0) ? PTMO : ETMO) + 8, "R9 timeout too late",
          cyc - last_wr_cyc, (op == 0) ? PTMO : ETMO);
    end else begin
      chk(busy_left == 0, "R6 done while flash busy", busy_left, 0);
      if (op == 0) begin
        chk(n_final >= 4 && n_final <= 5, "R7 settled read count", n_final, 4);
        chk(last_gap >= SETL, "R8 settle gap", last_gap, SETL);
      end else
        chk(n_final >= 3 && n_final <= 4, "R6 settled read count", n_final, 3);
    end
    @(negedge clk);
    chk(!done && !busy, "R10 pulse and idle after done", {done, busy}, 0);
    repeat (6) @(negedge clk);
    chk(nwr == wr_total(op) && !busy, "R1 no activity after done", nwr, wr_total(op));
  endtask

  initial begin
    int op, b, g;
    logic [DW-1:0] m;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr && !rd && !err, "R10 reset state", {busy, done, wr, rd, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_op(0, 18'h12345, 16'hBEEF, 0, 0, 16'h0, 0);
    run_op(0, 18'h00010, 16'h1234, 10, 5, 16'h0, 0);
    run_op(1, 18'h3E000, 16'h0, 12, 7, 16'h0, 0);
    run_op(2, 18'h08000, 16'h0, 20, 0, 16'h0, 1);
    run_op(3, 18'h00000, 16'h0, 5, 3, 16'h0, 0);
    run_op(0, 18'h2AAAA, 16'h5A5A, 6, 0, 16'h0100, 0);
    run_op(0, 18'h11111, 16'h8080, 100000, 0, 16'h0, 0);
    run_op(2, 18'h10000, 16'h0, 100000, 0, 16'h0, 0);
    for (int i = 0; i < 24; i++) begin
      op = $urandom_range(0, 3);
      b = $urandom_range(0, 30);
      g = (b >= 3 && $urandom_range(0, 1) == 1) ? $urandom_range(2, b - 1) : 0;
      m = (op == 0 && $urandom_range(0, 3) == 0) ? (16'h1 << $urandom_range(8, 15)) : 16'h0;
      run_op(op, AW'($urandom), DW'($urandom), b, g, m, (i % 5) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule